// File: doc/BRIEF.md
# Word-Addressed Load/Store Unit

This block executes the data-movement operations of a processor whose memory is built from 64-bit words. A request names one of five operation kinds: a register move, a low-half immediate load, a high-half immediate load, a memory load or a memory store. It also carries an access size, the base register value, a signed 32-bit immediate, the source register value and the current value of the destination register. The unit forms the effective address as the base plus the sign-extended immediate. The plain indirect form is the same request with an immediate of zero.

Register results leave on a write-back port. Memory is reached through a synchronous 256-word port: address, write data and write enable are outputs, and read data returns one cycle after the address. Stores narrower than a word are done as a read followed by a merged write, so the bits of the word outside the stored field keep their value. The unit takes one request at a time and shows with `ready_o` when it can accept the next one.

Top module: `word_lsu`

## Requirements
- R1: A request is accepted on a rising edge where `req_i` and `ready_o` are both high. The effective address is `base_i` plus `imm_i` sign-extended to 64 bits, and its low 8 bits pick the memory word.
- R2: When a load (kind 3) or store (kind 4) has any effective-address bit above bit 7 set, `err_o` and `done_o` are high for one cycle right after acceptance, and in that cycle neither `mem_we_o` nor `wb_en_o` is asserted.
- R3: A load returns the addressed word through `wb_data_o`, zero-extended from its low 8, 16, 32 or 64 bits for `size_i` 0, 1, 2 and 3. `wb_en_o` and `done_o` are high in the second cycle after acceptance.
- R4: A 64-bit store (`size_i`=3) writes all of `src_i` to the addressed word, with `mem_we_o` and `done_o` high in the first cycle after acceptance.
- R5: A store of size 0, 1 or 2 replaces only the low 8, 16 or 32 bits of the addressed word with the same bits of `src_i`. The other bits keep their value. The write happens in the second cycle after acceptance, together with `done_o`.
- R6: The low-half immediate load (kind 1) writes `imm_i` into bits 31:0 of the result and takes bits 63:32 from `dst_i` unchanged, with no sign extension.
- R7: The high-half immediate load (kind 2) writes `imm_i` into bits 63:32 of the result and takes bits 31:0 from `dst_i`.
- R8: A register move (kind 0) returns `src_i` zero-extended from the width chosen by `size_i`. Moves and immediate loads finish in the first cycle after acceptance.
- R9: While `ready_o` is low, `req_i` is ignored: it starts no access and changes no memory word.
- R10: `done_o` is a one-cycle pulse, and `ready_o` is high again in the cycle after it. After reset `ready_o` is high and `done_o`, `err_o`, `wb_en_o` and `mem_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| ready_o | output | 1 | Unit idle, request can be taken |
| kind_i | input | 3 | 0 move, 1 low-half immediate, 2 high-half immediate, 3 load, 4 store |
| size_i | input | 2 | 0: 8, 1: 16, 2: 32, 3: 64 bits |
| base_i | input | 64 | Base register value |
| imm_i | input | 32 | Signed displacement or immediate |
| src_i | input | 64 | Source register value |
| dst_i | input | 64 | Current destination register value |
| wb_en_o | output | 1 | Write-back strobe |
| wb_data_o | output | 64 | Write-back value |
| done_o | output | 1 | Operation finished |
| err_o | output | 1 | Address out of range |
| mem_addr_o | output | 8 | Memory word address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 64 | Memory write data |
| mem_rdata_i | input | 64 | Memory read data, one cycle after the address |

## Verification
Moves, immediate loads, 64-bit stores and range errors finish one cycle after the accepting edge. Loads and narrow stores finish two cycles after it, because the memory read sits between the address and the result. The bench drives inputs on falling edges and takes the cycle count from the accepting edge to the first sample with `done_o` high. It checks that count against the expected latency for each kind, and it reads results only in the cycle `done_o` marks. At the start of the next request it also checks that `done_o` has dropped and `ready_o` has returned.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [2:0] {
    K_MOVE   = 3'd0,
    K_IMM_LO = 3'd1,
    K_IMM_HI = 3'd2,
    K_LOAD   = 3'd3,
    K_STORE  = 3'd4
  } lsu_kind_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } lsu_size_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_EXEC  = 2'd1,
    S_LDATA = 2'd2,
    S_MERGE = 2'd3
  } lsu_state_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int DATA_W = 64,
  parameter int DISP_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] word_o,
  output logic              oor_o
);
  logic [DATA_W-1:0] eff;

  assign eff    = base_i + {{(DATA_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign word_o = eff[ADDR_W-1:0];
  assign oor_o  = |eff[DATA_W-1:ADDR_W];
endmodule

// File: rtl/lsu_fmt.sv
module lsu_fmt
  import lsu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  lsu_size_e         size_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] ext_o,
  output logic [DATA_W-1:0] merge_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] mask;

  always_comb begin
    case (size_i)
      SZ_8:    mask = {{(DATA_W-8){1'b0}}, {8{1'b1}}};
      SZ_16:   mask = {{(DATA_W-16){1'b0}}, {16{1'b1}}};
      SZ_32:   mask = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      default: mask = {DATA_W{1'b1}};
    endcase
  end

  assign ext_o   = word_i & mask;
  assign merge_o = (word_i & ~mask) | (src_i & mask);
endmodule

// File: rtl/word_lsu.sv
module word_lsu
  import lsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              ready_o,
  input  logic [2:0]        kind_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W/2-1:0] imm_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int HALF_W = DATA_W / 2;

  lsu_state_e          state_q, state_d;
  lsu_kind_e           kind_q;
  lsu_size_e           size_q;
  logic [ADDR_W-1:0]   word_q, word_d;
  logic                oor_q, oor_d;
  logic [DATA_W-1:0]   src_q, dst_q;
  logic [HALF_W-1:0]   imm_q;
  logic [DATA_W-1:0]   fmt_word, fmt_ext, fmt_merge;
  logic                take;

  lsu_agen #(.DATA_W(DATA_W), .DISP_W(HALF_W), .ADDR_W(ADDR_W)) u_agen (
    .base_i (base_i),
    .disp_i (imm_i),
    .word_o (word_d),
    .oor_o  (oor_d)
  );

  // memory word feeds the formatter once read data is back, else the source register
  assign fmt_word = (state_q == S_LDATA || state_q == S_MERGE) ? mem_rdata_i : src_q;

  lsu_fmt #(.DATA_W(DATA_W)) u_fmt (
    .size_i  (size_q),
    .word_i  (fmt_word),
    .src_i   (src_q),
    .ext_o   (fmt_ext),
    .merge_o (fmt_merge)
  );

  assign ready_o = (state_q == S_IDLE);
  assign take    = ready_o && req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_MOVE;
      size_q  <= SZ_8;
      word_q  <= '0;
      oor_q   <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      imm_q   <= '0;
    end else begin
      state_q <= state_d;
      if (take) begin
        kind_q <= lsu_kind_e'(kind_i);
        size_q <= lsu_size_e'(size_i);
        word_q <= word_d;
        oor_q  <= oor_d;
        src_q  <= src_i;
        dst_q  <= dst_i;
        imm_q  <= imm_i;
      end
    end
  end

  logic is_mem;
  assign is_mem = (kind_q == K_LOAD) || (kind_q == K_STORE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (req_i) state_d = S_EXEC;
      S_EXEC: begin
        state_d = S_IDLE;
        if (!oor_q && kind_q == K_LOAD) state_d = S_LDATA;
        if (!oor_q && kind_q == K_STORE && size_q != SZ_64) state_d = S_MERGE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    wb_en_o     = 1'b0;
    wb_data_o   = fmt_ext;
    done_o      = 1'b0;
    err_o       = 1'b0;
    mem_addr_o  = word_q;
    mem_we_o    = 1'b0;
    mem_wdata_o = src_q;
    case (state_q)
      S_EXEC: begin
        if (is_mem && oor_q) begin
          err_o  = 1'b1;
          done_o = 1'b1;
        end else begin
          case (kind_q)
            K_MOVE: begin
              wb_en_o = 1'b1;
              done_o  = 1'b1;
            end
            K_IMM_LO: begin
              wb_en_o   = 1'b1;
              wb_data_o = {dst_q[DATA_W-1:HALF_W], imm_q};
              done_o    = 1'b1;
            end
            K_IMM_HI: begin
              wb_en_o   = 1'b1;
              wb_data_o = {imm_q, dst_q[HALF_W-1:0]};
              done_o    = 1'b1;
            end
            K_LOAD: ;
            K_STORE: begin
              if (size_q == SZ_64) begin
                mem_we_o = 1'b1;
                done_o   = 1'b1;
              end
            end
            default: done_o = 1'b1;
          endcase
        end
      end
      S_LDATA: begin
        wb_en_o = 1'b1;
        done_o  = 1'b1;
      end
      S_MERGE: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = fmt_merge;
        done_o      = 1'b1;
      end
      default: ;
    endcase
  end

  assert_err_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && !mem_we_o && !wb_en_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));

  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(mem_addr_o));

  assert_wide_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && state_q == S_EXEC) |-> (mem_wdata_o == $past(src_i)));

  assert_imm_lo_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o && kind_q == K_IMM_LO) |-> (wb_data_o[DATA_W-1:HALF_W] == $past(dst_i[DATA_W-1:HALF_W])));

  assert_rmw_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && state_q == S_MERGE && size_q == SZ_32) |->
      (mem_wdata_o[DATA_W-1:HALF_W] == mem_rdata_i[DATA_W-1:HALF_W]));

  assert_we_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || wb_en_o) |-> done_o);
endmodule

// File: tb/tb_word_lsu.sv
`timescale 1ns/1ps
module tb_word_lsu;
  localparam logic [2:0] KM = 3'd0, KL = 3'd1, KH = 3'd2, KLD = 3'd3, KST = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        rdy;
  logic [2:0]  kind = '0;
  logic [1:0]  size = '0;
  logic [63:0] base = '0;
  logic [31:0] imm = '0;
  logic [63:0] src = '0;
  logic [63:0] dst = '0;
  logic        wb_en, done, err, we;
  logic [63:0] wb_data, wdata, rdata;
  logic [7:0]  addr;

  logic [63:0] mem     [256];
  logic [63:0] ref_mem [256];

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  word_lsu dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(rdy),
    .kind_i(kind), .size_i(size), .base_i(base), .imm_i(imm),
    .src_i(src), .dst_i(dst), .wb_en_o(wb_en), .wb_data_o(wb_data),
    .done_o(done), .err_o(err), .mem_addr_o(addr), .mem_we_o(we),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

  function automatic logic [63:0] msk(input int sz);
    case (sz)
      0: msk = 64'hFF;
      1: msk = 64'hFFFF;
      2: msk = 64'hFFFF_FFFF;
      default: msk = '1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] k, input int sz, input logic [63:0] b,
                       input logic [31:0] im, input logic [63:0] s, input logic [63:0] d,
                       output int lat, output logic [63:0] wbv, output logic wbe, output logic er);
    @(negedge clk);
    chk(rdy && !done, "R10 idle between ops", {62'd0, rdy, done}, 64'd2);
    kind = k; size = 2'(sz); base = b; imm = im; src = s; dst = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!done && lat < 6) begin
      @(negedge clk);
      lat++;
    end
    wbv = wb_data; wbe = wb_en; er = err;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    logic [63:0] v;
    logic e, er;
    for (int i = 0; i < 256; i++) begin
      mem[i]     = (64'(i) + 64'd1) * 64'h9E37_79B9_7F4A_7C15 ^ (64'(i) << 3);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(rdy && !done && !err && !wb_en && !we, "R10 reset state",
        {59'd0, rdy, done, err, wb_en, we}, 64'h10);
    rst_n = 1'b1;

    // R1 R3: full-word loads with negative displacement over every word
    for (int a = 0; a < 256; a++) begin
      issue(KLD, 3, 64'(a + 3), 32'hFFFF_FFFD, '0, '0, lat, v, e, er);
      chk(v == ref_mem[a] && e && !er, "R1 R3 load64 data", v, ref_mem[a]);
      chk(lat == 2, "R3 load latency", 64'(lat), 64'd2);
    end

    // R3: narrow loads zero-extend
    for (int sz = 0; sz < 3; sz++)
      for (int a = 0; a < 256; a += 17) begin
        issue(KLD, sz, 64'(a), 32'd0, '0, '0, lat, v, e, er);
        chk(v == (ref_mem[a] & msk(sz)) && e, "R3 sized load", v, ref_mem[a] & msk(sz));
      end

    // R4 R5: stores of each size
    for (int sz = 0; sz < 4; sz++)
      for (int j = 0; j < 20; j++) begin
        int a = (sz * 61 + j * 13) % 256;
        logic [63:0] d = {32'(j) ^ 32'hC3A5_5A3C, 32'(sz * 1000 + j) ^ 32'h8765_4321};
        issue(KST, sz, 64'(a - 4), 32'd4, d, '0, lat, v, e, er);
        ref_mem[a] = (ref_mem[a] & ~msk(sz)) | (d & msk(sz));
        chk(lat == (sz == 3 ? 1 : 2) && !e && !er, sz == 3 ? "R4 store latency" : "R5 store latency",
            64'(lat), sz == 3 ? 64'd1 : 64'd2);
      end

    // R2: out-of-range accesses
    issue(KLD, 3, 64'd256, 32'd0, '0, '0, lat, v, e, er);
    chk(er && !e && lat == 1, "R2 load above range", {62'd0, er, e}, 64'd2);
    issue(KST, 3, 64'd0, 32'hFFFF_FFFF, 64'h1111, '0, lat, v, e, er);
    chk(er && lat == 1, "R2 store negative address", {63'd0, er}, 64'd1);
    issue(KST, 0, 64'h1_0000_0010, 32'd0, 64'h2222, '0, lat, v, e, er);
    chk(er && lat == 1, "R2 store high bits", {63'd0, er}, 64'd1);
    issue(KLD, 3, 64'd0, 32'h8000_0000, '0, '0, lat, v, e, er);
    chk(er, "R2 large negative displacement", {63'd0, er}, 64'd1);
    issue(KLD, 3, 64'd255, 32'd0, '0, '0, lat, v, e, er);
    chk(!er && v == ref_mem[255], "R1 top word", v, ref_mem[255]);
    issue(KLD, 3, 64'd300, 32'hFFFF_FFD3, '0, '0, lat, v, e, er);
    chk(!er && v == ref_mem[255], "R1 wrap to top word", v, ref_mem[255]);

    // R6 R7: immediate halves
    issue(KL, 3, '0, 32'h1234_5678, '0, 64'hAAAA_BBBB_CCCC_DDDD, lat, v, e, er);
    chk(v == 64'hAAAA_BBBB_1234_5678 && e && lat == 1, "R6 low immediate", v, 64'hAAAA_BBBB_1234_5678);
    issue(KL, 0, '0, 32'hFFFF_0000, '0, 64'h0123_4567_89AB_CDEF, lat, v, e, er);
    chk(v == 64'h0123_4567_FFFF_0000, "R6 no sign extension", v, 64'h0123_4567_FFFF_0000);
    issue(KH, 3, '0, 32'h9ABC_DEF0, '0, 64'hAAAA_BBBB_CCCC_DDDD, lat, v, e, er);
    chk(v == 64'h9ABC_DEF0_CCCC_DDDD && e && lat == 1, "R7 high immediate", v, 64'h9ABC_DEF0_CCCC_DDDD);

    // R8: moves
    for (int sz = 0; sz < 4; sz++) begin
      logic [63:0] s = 64'hF1E2_D3C4_B5A6_9788 ^ 64'(sz);
      issue(KM, sz, 64'hFFFF_0000_0000_0000, '0, s, '1, lat, v, e, er);
      chk(v == (s & msk(sz)) && e && !er && lat == 1, "R8 move", v, s & msk(sz));
    end

    // R9: request held during a load is ignored
    @(negedge clk);
    kind = KLD; size = 2'd3; base = 64'd40; imm = '0; req = 1'b1;
    @(negedge clk);
    chk(!done, "R10 no early done", {63'd0, done}, 64'd0);
    kind = KST; base = 64'd41; src = 64'hDEAD_BEEF_0000_0001;
    @(negedge clk);
    chk(done && wb_data == ref_mem[40], "R9 load while req held", wb_data, ref_mem[40]);
    req = 1'b0;

    // read back the whole memory (R5 merges, R2 and R9 leave words intact)
    for (int a = 0; a < 256; a++) begin
      issue(KLD, 3, 64'(a), 32'd0, '0, '0, lat, v, e, er);
      chk(v == ref_mem[a], "R5 R9 R2 memory contents", v, ref_mem[a]);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule